// File: doc/BRIEF.md
# Synchronous Buck Phase Gate Sequencer

This block is the clocked control logic for one phase of a synchronous buck converter. It turns an already digitized three-level PWM command into enables for the high-side and low-side gate drivers. A PWM low or high selects which switch conducts. A mid-level (tri-state) indication that persists long enough turns both switches off. Before either gate turns on, the block waits until the opposite gate is sensed discharged and a minimum dead time has passed. High-side pulses are never shorter than a minimum on-time.

Two modes change the low-side behaviour. In diode emulation, the low-side switch opens at the zero crossing of the inductor current once a blanking window has expired. A tri-state command also opens it after the hold-off, whatever the current. A drive enable and a supply-good flag override everything, and the drive enable takes priority over the supply flag. A thermal warning with hysteresis is derived from a digital temperature code and has no effect on the gates. All inputs except the temperature code pass through two-flop synchronizers. Every delay is a parameter counted in clock cycles.

Top module: `buck_gate_ctrl`

## Requirements
- R1: The PWM level inputs are treated as one-hot, and `pwm_mid_i` takes priority over `pwm_hi_i`, which takes priority over `pwm_lo_i`. With no input active, the last command is kept. In steady state, a high command gives `hs_on_o`=1 and `ls_on_o`=0, and a low command gives `ls_on_o`=1 and `hs_on_o`=0.
- R2: A mid-level indication held for HOLDOFF_CYC consecutive cycles or more drives both gates off. A shorter excursion that returns to the same level leaves the conducting gate on without interruption.
- R3: `hs_on_o` and `ls_on_o` are never 1 together. A gate turns on only after the opposite gate's synchronized sense-low input reads 1 and both outputs have been 0 for at least DEAD_CYC cycles. While the sense input stays 0, the gate stays off.
- R4: With `emul_en_ni`=0 and a low command, the low-side gate opens once it has been on for BLANK_CYC cycles and `zc_i`=1 (current at or below zero). It then stays off until the command leaves low. With `emul_en_ni`=1, `zc_i` has no effect.
- R5: In diode emulation, a low-side gate that is still conducting turns off after the tri-state hold-off, even with `zc_i`=0.
- R6: `drv_en_i`=0 forces both gates off within 4 cycles, and PWM is ignored while it stays 0. The synchronizer resets this input to the disabled value, so both gates are off after reset.
- R7: `supply_ok_i`=0 forces both gates off within 4 cycles and holds them off. This override ranks below R6 and above the tri-state and PWM commands.
- R8: `hot_no` is active low. It goes to 0 one cycle after `temp_i` >= TEMP_SET, returns to 1 one cycle after `temp_i` < TEMP_CLR, and otherwise keeps its value. It does not affect the gates.
- R9: Unless a forced-off condition intervenes, every high-side pulse lasts at least MIN_ON_CYC cycles, even for a one-cycle high command.
- R10: When the command leaves tri-state for high or low, switching resumes with the full dead-time and sense sequencing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hi_i | input | 1 | PWM above the high threshold |
| pwm_lo_i | input | 1 | PWM below the low threshold |
| pwm_mid_i | input | 1 | PWM in the mid-level (tri-state) window |
| drv_en_i | input | 1 | Drive enable; 0 forces both gates off |
| supply_ok_i | input | 1 | Logic supply above its lockout level |
| emul_en_ni | input | 1 | Diode emulation enable, active low |
| zc_i | input | 1 | Inductor current at or below zero |
| hs_low_i | input | 1 | High-side gate sensed below its low threshold |
| ls_low_i | input | 1 | Low-side gate sensed below its low threshold |
| temp_i | input | TEMP_W | Junction temperature code in °C |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| hot_no | output | 1 | Thermal warning, active low |

## Verification
The bench holds the mid-level input for one cycle less than the hold-off. A decoder that counts wrongly, or that does not restart its count, would drop the high-side gate during this glitch. The bench also holds a low-side sense input at 0 while demanding the high side, which exposes a fixed-delay design that turns on into a conducting opposite switch. A one-cycle high pulse measures the high-side on-time exactly and catches runt pulses. The low-side on-time is counted under emulation to catch a blanking window that is off by one or absent. The bench then checks that the gate stays open after the zero crossing ends and reopens only on a new low command. Thermal hysteresis is probed between the two thresholds, where a design with a single threshold would release the warning too early.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;
  typedef enum logic [1:0] {
    CMD_OFF = 2'd0,
    CMD_HI  = 2'd1,
    CMD_LO  = 2'd2
  } gate_cmd_e;
endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bgc_tri_decode.sv
module bgc_tri_decode
  import buck_gate_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 13
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hi_i,
  input  logic      lo_i,
  input  logic      mid_i,
  output gate_cmd_e cmd_o
);
  localparam int unsigned CW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CW-1:0] H_LAST = CW'(HOLDOFF_CYC - 1);

  logic [CW-1:0] cnt_q;
  gate_cmd_e     cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmd_q <= CMD_OFF;
    end else if (mid_i) begin
      // mid level must persist HOLDOFF_CYC samples before it wins
      if (cnt_q == H_LAST) cmd_q <= CMD_OFF;
      else                 cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
      if (hi_i)      cmd_q <= CMD_HI;
      else if (lo_i) cmd_q <= CMD_LO;
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/bgc_gate_seq.sv
module bgc_gate_seq
  import buck_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYC   = 2,
  parameter int unsigned BLANK_CYC  = 4,
  parameter int unsigned MIN_ON_CYC = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  gate_cmd_e cmd_i,
  input  logic      kill_i,
  input  logic      emul_i,
  input  logic      zc_i,
  input  logic      hs_low_i,
  input  logic      ls_low_i,
  output logic      hs_on_o,
  output logic      ls_on_o
);
  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam int unsigned OW = $clog2(MIN_ON_CYC + 1);
  localparam logic [DW-1:0] DEAD_MAX   = DW'(DEAD_CYC);
  localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CYC - 1);
  localparam logic [OW-1:0] ON_LAST    = OW'(MIN_ON_CYC - 1);

  logic          hs_q, ls_q, de_done_q;
  logic [DW-1:0] dead_q;
  logic [BW-1:0] blank_q;
  logic [OW-1:0] on_q;

  logic want_hs, want_ls, hs_hold, dead_ok, de_cut, hs_d, ls_d;

  assign want_hs = (cmd_i == CMD_HI);
  assign want_ls = (cmd_i == CMD_LO) && !de_done_q;
  assign hs_hold = hs_q && (on_q < ON_LAST);
  assign dead_ok = (dead_q == DEAD_MAX);
  assign de_cut  = emul_i && zc_i && (blank_q == BLANK_LAST);

  always_comb begin
    if (kill_i) begin
      hs_d = 1'b0;
      ls_d = 1'b0;
    end else begin
      hs_d = hs_q ? (want_hs || hs_hold)
                  : (want_hs && !ls_q && ls_low_i && dead_ok);
      ls_d = ls_q ? (want_ls && !de_cut)
                  : (want_ls && !hs_q && hs_low_i && dead_ok);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q      <= 1'b0;
      ls_q      <= 1'b0;
      de_done_q <= 1'b0;
      dead_q    <= '0;
      blank_q   <= '0;
      on_q      <= '0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
      if (hs_q || ls_q)         dead_q <= '0;
      else if (!dead_ok)        dead_q <= dead_q + 1'b1;
      if (!ls_q)                blank_q <= '0;
      else if (blank_q != BLANK_LAST) blank_q <= blank_q + 1'b1;
      if (!hs_q)                on_q <= '0;
      else if (hs_hold)         on_q <= on_q + 1'b1;
      if (cmd_i != CMD_LO)      de_done_q <= 1'b0;
      else if (ls_q && de_cut)  de_done_q <= 1'b1;
    end
  end

  assign hs_on_o = hs_q;
  assign ls_on_o = ls_q;
endmodule

// File: rtl/bgc_therm.sv
module bgc_therm #(
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned TEMP_SET = 160,
  parameter int unsigned TEMP_CLR = 135
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_no
);
  localparam logic [TEMP_W-1:0] SET_C = TEMP_W'(TEMP_SET);
  localparam logic [TEMP_W-1:0] CLR_C = TEMP_W'(TEMP_CLR);

  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hot_q <= 1'b0;
    else if (temp_i >= SET_C) hot_q <= 1'b1;
    else if (temp_i < CLR_C)  hot_q <= 1'b0;
  end

  assign hot_no = ~hot_q;
endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
  import buck_gate_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYC = 13,
  parameter int unsigned DEAD_CYC    = 2,
  parameter int unsigned BLANK_CYC   = 4,
  parameter int unsigned MIN_ON_CYC  = 3,
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned TEMP_SET    = 160,
  parameter int unsigned TEMP_CLR    = 135
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_hi_i,
  input  logic              pwm_lo_i,
  input  logic              pwm_mid_i,
  input  logic              drv_en_i,
  input  logic              supply_ok_i,
  input  logic              emul_en_ni,
  input  logic              zc_i,
  input  logic              hs_low_i,
  input  logic              ls_low_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hs_on_o,
  output logic              ls_on_o,
  output logic              hot_no
);
  localparam int unsigned NSYNC = 9;
  // reset values: disabled, supply bad, emulation off, gates sensed low
  localparam logic [NSYNC-1:0] SYNC_RST = 9'b000_001_011;

  logic [NSYNC-1:0] raw, syn;
  logic pwm_hi_s, pwm_lo_s, pwm_mid_s, dis_en_s, sup_s, emul_n_s, zc_s;
  logic hs_low_s, ls_low_s;
  gate_cmd_e cmd;

  assign raw = {pwm_hi_i, pwm_lo_i, pwm_mid_i, drv_en_i, supply_ok_i,
                emul_en_ni, zc_i, hs_low_i, ls_low_i};
  assign {pwm_hi_s, pwm_lo_s, pwm_mid_s, dis_en_s, sup_s,
          emul_n_s, zc_s, hs_low_s, ls_low_s} = syn;

  bgc_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (raw), .q_o (syn)
  );

  bgc_tri_decode #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_dec (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .hi_i (pwm_hi_s), .lo_i (pwm_lo_s), .mid_i (pwm_mid_s),
    .cmd_o (cmd)
  );

  bgc_gate_seq #(
    .DEAD_CYC (DEAD_CYC), .BLANK_CYC (BLANK_CYC), .MIN_ON_CYC (MIN_ON_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .kill_i   (!dis_en_s || !sup_s),
    .emul_i   (!emul_n_s),
    .zc_i     (zc_s),
    .hs_low_i (hs_low_s),
    .ls_low_i (ls_low_s),
    .hs_on_o  (hs_on_o),
    .ls_on_o  (ls_on_o)
  );

  bgc_therm #(
    .TEMP_W (TEMP_W), .TEMP_SET (TEMP_SET), .TEMP_CLR (TEMP_CLR)
  ) u_therm (
    .clk_i (clk_i), .rst_ni (rst_ni), .temp_i (temp_i), .hot_no (hot_no)
  );
endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int unsigned MIN_ON_CYC = 3,
  parameter int unsigned TEMP_W     = 8,
  parameter int unsigned TEMP_SET   = 160,
  parameter int unsigned TEMP_CLR   = 135
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hs_on_o,
  input logic              ls_on_o,
  input logic              hot_no,
  input logic [TEMP_W-1:0] temp_i,
  input logic              dis_en_s,
  input logic              sup_s,
  input logic              hs_low_s,
  input logic              ls_low_s
);
  localparam logic [TEMP_W-1:0] SET_C = TEMP_W'(TEMP_SET);
  localparam logic [TEMP_W-1:0] CLR_C = TEMP_W'(TEMP_CLR);

  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_on_o && ls_on_o));

  assert_hs_waits_sense_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(ls_low_s && !ls_on_o));

  assert_ls_waits_sense_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> $past(hs_low_s && !hs_on_o));

  assert_ls_dead_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> $past(!hs_on_o, 2));

  assert_disable_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_en_s |=> (!hs_on_o && !ls_on_o));

  assert_supply_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_s |=> (!hs_on_o && !ls_on_o));

  assert_hot_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= SET_C) |=> !hot_no);

  assert_hot_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i < CLR_C) |=> hot_no);

  generate
    if (MIN_ON_CYC >= 2) begin : g_min_on
      assert_min_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(hs_on_o) && dis_en_s && sup_s) |=> hs_on_o);
    end
  endgenerate
endmodule

bind buck_gate_ctrl bgc_checker #(
  .MIN_ON_CYC (MIN_ON_CYC), .TEMP_W (TEMP_W),
  .TEMP_SET (TEMP_SET), .TEMP_CLR (TEMP_CLR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hs_on_o  (hs_on_o),
  .ls_on_o  (ls_on_o),
  .hot_no   (hot_no),
  .temp_i   (temp_i),
  .dis_en_s (dis_en_s),
  .sup_s    (sup_s),
  .hs_low_s (hs_low_s),
  .ls_low_s (ls_low_s)
);

// File: tb/buck_gate_ctrl_bench.sv
`timescale 1ns/1ps
module buck_gate_ctrl_bench;
  localparam int HOLDOFF = 13;
  localparam int BLANK   = 4;
  localparam int MIN_ON  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_hi = 0, pwm_lo = 0, pwm_mid = 0;
  logic drv_en = 1, sup_ok = 1, emul_n = 1, zc = 0, stuck_ls = 0;
  logic [7:0] temp = 8'd25;
  logic hs_on, ls_on, hot_n, hs_low, ls_low;

  int checks = 0, errors = 0;
  int hs_cyc = 0, ls_cyc = 0, overlap = 0, hs_falls = 0;
  logic hs_prev = 0;

  always #5 clk = ~clk;

  assign hs_low = !hs_on;
  assign ls_low = !ls_on && !stuck_ls;

  buck_gate_ctrl u_buck_gate_ctrl (
    .clk_i (clk), .rst_ni (rst_n),
    .pwm_hi_i (pwm_hi), .pwm_lo_i (pwm_lo), .pwm_mid_i (pwm_mid),
    .drv_en_i (drv_en), .supply_ok_i (sup_ok), .emul_en_ni (emul_n),
    .zc_i (zc), .hs_low_i (hs_low), .ls_low_i (ls_low), .temp_i (temp),
    .hs_on_o (hs_on), .ls_on_o (ls_on), .hot_no (hot_n)
  );

  always @(negedge clk) begin
    if (hs_on) hs_cyc++;
    if (ls_on) ls_cyc++;
    if (hs_on && ls_on) overlap++;
    if (hs_prev && !hs_on) hs_falls++;
    hs_prev = hs_on;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pwm(input logic h, input logic l, input logic m);
    pwm_hi = h; pwm_lo = l; pwm_mid = m;
  endtask

  task automatic t_reset;
    cyc(3);
    chk(!hs_on && !ls_on, "R6 reset gates off", {hs_on, ls_on}, 0);
    chk(hot_n, "R8 reset warning idle", hot_n, 1);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_basic;
    set_pwm(0, 1, 0); cyc(20);
    chk(ls_on && !hs_on, "R1 low command", {hs_on, ls_on}, 1);
    set_pwm(1, 0, 0); cyc(20);
    chk(hs_on && !ls_on, "R1 high command", {hs_on, ls_on}, 2);
  endtask

  task automatic t_sense;
    set_pwm(0, 1, 0); cyc(20);
    stuck_ls = 1'b1;
    set_pwm(1, 0, 0); cyc(20);
    chk(!hs_on && !ls_on, "R3 high side waits for low-side sense", {hs_on, ls_on}, 0);
    stuck_ls = 1'b0; cyc(20);
    chk(hs_on, "R3 high side on after sense clears", hs_on, 1);
  endtask

  task automatic t_tri_short;
    set_pwm(1, 0, 0); cyc(20);
    hs_falls = 0;
    set_pwm(0, 0, 1); cyc(HOLDOFF - 1);
    set_pwm(1, 0, 0); cyc(10);
    chk(hs_on && hs_falls == 0, "R2 short tri excursion ignored", hs_falls, 0);
  endtask

  task automatic t_tri_long;
    set_pwm(0, 0, 1); cyc(HOLDOFF + 8);
    chk(!hs_on && !ls_on, "R2 tri hold-off turns both off", {hs_on, ls_on}, 0);
    set_pwm(0, 1, 0); cyc(20);
    chk(ls_on && !hs_on, "R10 resume low after tri", {hs_on, ls_on}, 1);
    set_pwm(0, 0, 1); cyc(HOLDOFF + 8);
    set_pwm(1, 0, 0); cyc(20);
    chk(hs_on && !ls_on, "R10 resume high after tri", {hs_on, ls_on}, 2);
  endtask

  task automatic t_min_on;
    set_pwm(0, 0, 1); cyc(HOLDOFF + 8);
    hs_cyc = 0;
    set_pwm(1, 0, 0); cyc(1);
    set_pwm(0, 1, 0); cyc(30);
    chk(hs_cyc == MIN_ON, "R9 runt pulse stretched", hs_cyc, MIN_ON);
  endtask

  task automatic t_emul;
    emul_n = 0; zc = 1;
    set_pwm(1, 0, 0); cyc(20);
    ls_cyc = 0;
    set_pwm(0, 1, 0); cyc(30);
    chk(ls_cyc == BLANK, "R4 low side on for blanking only", ls_cyc, BLANK);
    zc = 0; cyc(10);
    chk(!ls_on, "R4 stays off after zero crossing", ls_on, 0);
    set_pwm(1, 0, 0); cyc(20);
    set_pwm(0, 1, 0); cyc(30);
    chk(ls_on, "R4 positive current keeps low side on", ls_on, 1);
    zc = 1; cyc(10);
    chk(!ls_on, "R4 zero crossing opens low side", ls_on, 0);
    emul_n = 1;
    set_pwm(1, 0, 0); cyc(20);
    set_pwm(0, 1, 0); cyc(30);
    chk(ls_on, "R4 crossing ignored without emulation", ls_on, 1);
    zc = 0;
  endtask

  task automatic t_emul_tri;
    emul_n = 0; zc = 0;
    set_pwm(0, 1, 0); cyc(20);
    set_pwm(0, 0, 1); cyc(HOLDOFF + 8);
    chk(!ls_on, "R5 tri opens low side in emulation", ls_on, 0);
    emul_n = 1;
  endtask

  task automatic t_disable;
    set_pwm(1, 0, 0); cyc(20);
    drv_en = 0; cyc(4);
    chk(!hs_on && !ls_on, "R6 disable forces off", {hs_on, ls_on}, 0);
    set_pwm(0, 1, 0); cyc(10);
    chk(!hs_on && !ls_on, "R6 PWM ignored while disabled", {hs_on, ls_on}, 0);
    drv_en = 1; cyc(20);
    chk(ls_on, "R6 resume after enable", ls_on, 1);
  endtask

  task automatic t_supply;
    set_pwm(1, 0, 0); cyc(20);
    sup_ok = 0; cyc(4);
    chk(!hs_on && !ls_on, "R7 supply loss clamps gates", {hs_on, ls_on}, 0);
    cyc(10);
    chk(!hs_on && !ls_on, "R7 gates held off", {hs_on, ls_on}, 0);
    sup_ok = 1; cyc(20);
    chk(hs_on, "R7 resume on supply good", hs_on, 1);
  endtask

  task automatic t_therm;
    temp = 8'd159; cyc(2);
    chk(hot_n, "R8 below set", hot_n, 1);
    temp = 8'd160; cyc(2);
    chk(!hot_n && hs_on, "R8 set at threshold, gates unaffected", hot_n, 0);
    temp = 8'd140; cyc(2);
    chk(!hot_n, "R8 hysteresis hold", hot_n, 0);
    temp = 8'd135; cyc(2);
    chk(!hot_n, "R8 held at clear threshold", hot_n, 0);
    temp = 8'd134; cyc(2);
    chk(hot_n, "R8 release below clear", hot_n, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_sense();
    t_tri_short();
    t_tri_long();
    t_min_on();
    t_emul();
    t_emul_tri();
    t_disable();
    t_supply();
    t_therm();
    chk(overlap == 0, "R3 no overlap over run", overlap, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule